// File: doc/BRIEF.md
# Tagged Memory with Per-Use Access Traps

This block is a word-addressed memory in which every stored word carries three watch bits beside its data. Each watch bit stands for one way the word can be used: as an instruction, as a data operand, or as an indirect pointer. Every processor access names its kind. If the watch bit for that kind is set on the addressed word, the block raises a trap in the same cycle. The access itself still completes normally and adds no wait state. Because every location carries its own watch bits, the whole memory is watched at once, not just a few addresses held in comparator registers.

A debug port reads and writes the watch bits of any word and never touches the data. On the first trap the block latches the address, the access kind and the direction into a syndrome record, so that handler software can classify the event. The record holds until software clears it. Any later trap that arrives while the record is held sets a sticky overflow flag and does not overwrite the record.

The processor port has a valid strobe but no ready signal. The block never applies back-pressure: every strobed access is accepted and answered in its own cycle. Read data, the trap pulse and the debug tag read are all combinational from the current address.

Top module: `tagged_trap_mem`

## Requirements
- R1: After reset, no syndrome is held, the overflow flag is 0, the trap output is 0, and every word's watch bits read back as 0.
- R2: A processor write stores its data at the clock edge. A processor read returns the stored word combinationally in the same cycle.
- R3: A processor write never changes the watch bits of any word.
- R4: A debug write replaces the three watch bits of the addressed word at the clock edge. A debug read returns them combinationally. Neither operation changes the stored data.
- R5: The kind code is 0 for an instruction fetch, 1 for a data operand and 2 for an indirect fetch. These check watch bit 0, bit 1 and bit 2 respectively. Code 3 is reserved and never traps. `trap` is high exactly in the cycle of a strobed access whose watch bit is set, whether the access is a read or a write.
- R6: A trapping access still completes: a trapping read returns the stored data, and a trapping write stores its data.
- R7: A trap while no syndrome is held sets `syn_valid` at the next edge. It also latches the access address, the kind and the write flag.
- R8: While a syndrome is held and `syn_clear` is low, the record stays unchanged. A further trap sets `syn_overflow`, which stays set.
- R9: `syn_clear` empties the record and drops the overflow flag. If a trap occurs in the same cycle as the clear, that trap is captured as a fresh record and the overflow flag stays 0.
- R10: When a debug tag write and a processor access hit the same word in the same cycle, the trap decision uses the watch bits held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access strobe |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_kind | input | 2 | Access kind code (see R5) |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational |
| trap | output | 1 | Single-cycle trap pulse |
| dbg_valid | input | 1 | Debug access strobe |
| dbg_write | input | 1 | 1 to write the watch bits |
| dbg_addr | input | ADDR_W | Debug word address |
| dbg_wtag | input | 3 | Watch bits to write |
| dbg_rtag | output | 3 | Watch bits at dbg_addr, combinational |
| syn_clear | input | 1 | Empties the syndrome record |
| syn_valid | output | 1 | Syndrome record held |
| syn_addr | output | ADDR_W | Latched trap address |
| syn_kind | output | 2 | Latched access kind |
| syn_write | output | 1 | Latched write flag |
| syn_overflow | output | 1 | Sticky lost-trap flag |

## Verification
Two collisions need care. The first is a syndrome clear and a new trap in the same cycle. The bench forces this directly, and also lets it occur in random traffic where clears fire often on a handful of heavily tagged addresses. It is judged by whether the record next cycle holds the new trap with overflow at 0. The second is a debug tag write landing on the word the processor is accessing in that same cycle. The bench checks that the trap follows the old bits, and that a later debug read shows the new ones.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;
  localparam int TAG_W = 3;

  typedef enum logic [1:0] {
    USE_FETCH    = 2'd0,
    USE_OPERAND  = 2'd1,
    USE_INDIRECT = 2'd2,
    USE_RESERVED = 2'd3
  } use_kind_e;
endpackage

// File: rtl/tagmem_store.sv
module tagmem_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [TAG_W-1:0]  cpu_tag,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [TAG_W-1:0]  dbg_wtag,
  output logic [TAG_W-1:0]  dbg_rtag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];

  // Data words: no reset, written only by the processor port.
  always_ff @(posedge clk) begin
    if (cpu_we) data_q[cpu_addr] <= cpu_wdata;
  end

  // Watch bits: reset to zero, written only by the debug port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else if (dbg_we) begin
      tag_q[dbg_addr] <= dbg_wtag;
    end
  end

  assign cpu_rdata = data_q[cpu_addr];
  assign cpu_tag   = tag_q[cpu_addr];
  assign dbg_rtag  = tag_q[dbg_addr];
endmodule

// File: rtl/tagmem_match.sv
module tagmem_match
  import tagmem_pkg::*;
(
  input  logic             access,
  input  logic [1:0]       kind,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  logic sel;

  always_comb begin
    unique case (use_kind_e'(kind))
      USE_FETCH:    sel = tag[0];
      USE_OPERAND:  sel = tag[1];
      USE_INDIRECT: sel = tag[2];
      default:      sel = 1'b0;
    endcase
  end

  assign hit = access & sel;
endmodule

// File: rtl/tagmem_syndrome.sv
module tagmem_syndrome #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [1:0]        hit_kind,
  input  logic              hit_write,
  input  logic              clear,
  output logic              held,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [1:0]        rec_kind,
  output logic              rec_write,
  output logic              lost
);
  // The slot is free to capture when it is empty or is being cleared.
  logic slot_free;
  assign slot_free = clear | ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      rec_addr  <= '0;
      rec_kind  <= '0;
      rec_write <= 1'b0;
      lost      <= 1'b0;
    end else begin
      if (hit && slot_free) begin
        held      <= 1'b1;
        rec_addr  <= hit_addr;
        rec_kind  <= hit_kind;
        rec_write <= hit_write;
      end else if (clear) begin
        held <= 1'b0;
      end

      if (clear)         lost <= 1'b0;
      else if (hit && held) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/tagged_trap_mem.sv
module tagged_trap_mem
  import tagmem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_kind,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              trap,
  input  logic              dbg_valid,
  input  logic              dbg_write,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [2:0]        dbg_wtag,
  output logic [2:0]        dbg_rtag,
  input  logic              syn_clear,
  output logic              syn_valid,
  output logic [ADDR_W-1:0] syn_addr,
  output logic [1:0]        syn_kind,
  output logic              syn_write,
  output logic              syn_overflow
);
  logic [TAG_W-1:0] cur_tag;
  logic             hit;

  tagmem_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_valid & cpu_write),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_tag   (cur_tag),
    .dbg_we    (dbg_valid & dbg_write),
    .dbg_addr  (dbg_addr),
    .dbg_wtag  (dbg_wtag),
    .dbg_rtag  (dbg_rtag)
  );

  tagmem_match u_match (
    .access (cpu_valid),
    .kind   (cpu_kind),
    .tag    (cur_tag),
    .hit    (hit)
  );

  tagmem_syndrome #(
    .ADDR_W (ADDR_W)
  ) u_syn (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .hit_addr  (cpu_addr),
    .hit_kind  (cpu_kind),
    .hit_write (cpu_write),
    .clear     (syn_clear),
    .held      (syn_valid),
    .rec_addr  (syn_addr),
    .rec_kind  (syn_kind),
    .rec_write (syn_write),
    .lost      (syn_overflow)
  );

  assign trap = hit;
endmodule

// File: rtl/tagged_trap_mem_chk.sv
module tagged_trap_mem_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_write,
  input logic [1:0]        cpu_kind,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              trap,
  input logic              dbg_valid,
  input logic              dbg_write,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic [2:0]        dbg_rtag,
  input logic              syn_clear,
  input logic              syn_valid,
  input logic [ADDR_W-1:0] syn_addr,
  input logic [1:0]        syn_kind,
  input logic              syn_write,
  input logic              syn_overflow
);
  // R5: a trap needs a strobed access of a non-reserved kind
  assert_trap_needs_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (cpu_valid && cpu_kind != 2'd3));

  // R7: a trap into an empty record captures it
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !syn_valid) |=>
      (syn_valid && syn_addr == $past(cpu_addr) && syn_kind == $past(cpu_kind)
       && syn_write == $past(cpu_write)));

  // R8: a held record is frozen until cleared
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && !syn_clear) |=>
      (syn_valid && $stable(syn_addr) && $stable(syn_kind) && $stable(syn_write)));

  // R8: a trap over a held record sets overflow
  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && trap && !syn_clear) |=> syn_overflow);

  // R9: a clear with no trap empties the record
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_clear && !trap) |=> (!syn_valid && !syn_overflow));

  // R9: a clear with a trap captures a fresh record
  assert_clear_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_clear && trap) |=> (syn_valid && !syn_overflow && syn_addr == $past(cpu_addr)));

  // R3: processor writes leave the watch bits alone
  assert_cpu_keeps_tags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && !(dbg_valid && dbg_write)) |=>
      ($stable(dbg_addr) -> $stable(dbg_rtag)));
endmodule

bind tagged_trap_mem tagged_trap_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_valid    (cpu_valid),
  .cpu_write    (cpu_write),
  .cpu_kind     (cpu_kind),
  .cpu_addr     (cpu_addr),
  .trap         (trap),
  .dbg_valid    (dbg_valid),
  .dbg_write    (dbg_write),
  .dbg_addr     (dbg_addr),
  .dbg_rtag     (dbg_rtag),
  .syn_clear    (syn_clear),
  .syn_valid    (syn_valid),
  .syn_addr     (syn_addr),
  .syn_kind     (syn_kind),
  .syn_write    (syn_write),
  .syn_overflow (syn_overflow)
);

// File: tb/tb_tagged_trap_mem.sv
module tb_tagged_trap_mem;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [1:0]    cpu_kind = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          trap;
  logic          dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic [2:0]    dbg_wtag = '0;
  logic [2:0]    dbg_rtag;
  logic          syn_clear = 1'b0;
  logic          syn_valid;
  logic [AW-1:0] syn_addr;
  logic [1:0]    syn_kind;
  logic          syn_write;
  logic          syn_overflow;

  always #10 clk = ~clk;  // 50 MHz

  tagged_trap_mem #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model
  logic [DW-1:0] m_data [DEPTH];
  logic [2:0]    m_tag  [DEPTH];
  logic          m_sv, m_ovf, m_sw;
  logic [AW-1:0] m_sa;
  logic [1:0]    m_sk;

  function automatic logic exp_trap(logic v, logic [1:0] k, logic [2:0] t);
    if (!v || k == 2'd3) return 1'b0;
    return t[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic cv, input logic cw, input logic [1:0] ck,
                       input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                       input logic dv, input logic dw, input logic [AW-1:0] da,
                       input logic [2:0] dt, input logic clr);
    logic eh;
    @(negedge clk);
    cpu_valid = cv; cpu_write = cw; cpu_kind = ck; cpu_addr = ca; cpu_wdata = cd;
    dbg_valid = dv; dbg_write = dw; dbg_addr = da; dbg_wtag = dt; syn_clear = clr;
    #2;
    eh = exp_trap(cv, ck, m_tag[ca]);  // R10: old bits decide
    check("R5/R10 trap", 32'(trap), 32'(eh));
    if (cv && !cw) check(eh ? "R6 trapping read data" : "R2 read data",
                         32'(cpu_rdata), 32'(m_data[ca]));
    if (dv && !dw) check("R4 tag read", 32'(dbg_rtag), 32'(m_tag[da]));
    @(posedge clk);
    #1;
    if (cv && cw) m_data[ca] = cd;
    if (dv && dw) m_tag[da] = dt;
    if (clr) begin
      m_ovf = 1'b0;
      m_sv = eh;
      if (eh) begin m_sa = ca; m_sk = ck; m_sw = cw; end
    end else if (eh) begin
      if (m_sv) m_ovf = 1'b1;
      else begin m_sv = 1'b1; m_sa = ca; m_sk = ck; m_sw = cw; end
    end
    check("R7/R8/R9 syn_valid", 32'(syn_valid), 32'(m_sv));
    check("R8/R9 syn_overflow", 32'(syn_overflow), 32'(m_ovf));
    if (m_sv) begin
      check("R7/R8 syn_addr", 32'(syn_addr), 32'(m_sa));
      check("R7/R8 syn_kind", 32'(syn_kind), 32'(m_sk));
      check("R7/R8 syn_write", 32'(syn_write), 32'(m_sw));
    end
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_data[i] = '0; end
    m_sv = 0; m_ovf = 0; m_sw = 0; m_sa = '0; m_sk = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 syn_valid", 32'(syn_valid), 0);
    check("R1 syn_overflow", 32'(syn_overflow), 0);
    check("R1 trap", 32'(trap), 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      dbg_valid = 1; dbg_write = 0; dbg_addr = AW'(i);
      #2;
      check("R1 tags clear", 32'(dbg_rtag), 0);
    end
    // Fill all words (R2)
    for (int i = 0; i < DEPTH; i++)
      cycle(1, 1, 2'd1, AW'(i), DW'($urandom), 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++)
      cycle(1, 0, 2'd0, AW'(i), 0, 0, 0, 0, 0, 0);

    // R3: processor write on a tagged word keeps its bits
    cycle(0, 0, 0, 0, 0, 1, 1, 6'd5, 3'b110, 0);
    cycle(1, 1, 2'd0, 6'd5, 16'hBEEF, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1, 0, 6'd5, 0, 0);
    check("R3 tags after cpu write", 32'(dbg_rtag), 32'(3'b110));
    // R4: tag write leaves data alone
    cycle(1, 0, 2'd0, 6'd5, 0, 0, 0, 0, 0, 0);
    check("R4 data kept", 32'(cpu_rdata), 32'h0000BEEF);

    // R5: reserved kind never traps even with all bits set
    cycle(0, 0, 0, 0, 0, 1, 1, 6'd9, 3'b111, 0);
    cycle(1, 0, 2'd3, 6'd9, 0, 0, 0, 0, 0, 0);
    check("R5 reserved no trap", 32'(trap), 0);
    // R6/R7: trapping write lands and is captured
    cycle(1, 1, 2'd1, 6'd5, 16'h1234, 0, 0, 0, 0, 0);
    cycle(1, 0, 2'd0, 6'd5, 0, 0, 0, 0, 0, 0);
    check("R6 trapping write stored", 32'(cpu_rdata), 32'h00001234);
    // R8: second trap sets overflow
    cycle(1, 0, 2'd2, 6'd9, 0, 0, 0, 0, 0, 0);
    check("R8 overflow set", 32'(syn_overflow), 1);
    check("R8 first record kept", 32'(syn_addr), 5);
    // R9: clear together with a trap
    cycle(1, 0, 2'd0, 6'd9, 0, 0, 0, 0, 0, 1);
    check("R9 fresh record", 32'(syn_addr), 9);
    check("R9 overflow dropped", 32'(syn_overflow), 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R9 emptied", 32'(syn_valid), 0);
    // R10: same-cycle tag write and access on one word
    cycle(1, 0, 2'd0, 6'd12, 0, 1, 1, 6'd12, 3'b001, 0);
    check("R10 old bits used", 32'(syn_valid), 0);
    cycle(1, 0, 2'd0, 6'd12, 0, 1, 1, 6'd12, 3'b000, 0);
    check("R10 new bits took effect", 32'(syn_valid), 1);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a1, a2;
      a1 = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
      a2 = ($urandom % 3 == 0) ? a1 : AW'($urandom % 8);
      cycle(($urandom % 4) != 0, ($urandom % 3) == 0, 2'($urandom), a1, DW'($urandom),
            ($urandom % 3) == 0, ($urandom % 2) == 0, a2, 3'($urandom),
            ($urandom % 6) == 0);
    end
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule